// File: doc/BRIEF.md
# Multicore Spin-Table Release Controller

This block is a memory-mapped table with one 32-byte boot-release record per processor core. Boot code or a running core fills in a record over a narrow big-endian bus port, one byte, halfword or word at a time. When a record's 64-bit jump-address field has bit 0 clear, the owning core is let go. The block then raises that core's bit of a one-hot release vector for one clock. In the same clock it presents the start offset, the translation window base, the initial argument and the fixed window size on shared buses.

Record layout, by byte offset within the record:

| Offset | Size | Field |
|--------|------|-------|
| 0–7 | 64 bits | Jump address |
| 8–15 | 64 bits | Argument |
| 16–19 | 32 bits | Spare |
| 20–23 | 32 bits | Core identifier |
| 24–31 | 64 bits | Spare |

Record 0 belongs to the primary core, which never waits. Writes to it are dropped, and so are writes to records whose core is absent. All records can always be read, and a read changes nothing.

Top module: `spin_release_bank`

## Requirements
- R1: After reset, record i reads back a jump address of 1, an argument of i and a core identifier of i, with both spare fields zero.
- R2: Bus address bits [9:5] select the record and bits [4:0] the byte within it, in the layout above. Accesses are 1, 2 or 4 bytes, and address bits below the access size are ignored. Write and read data are right-justified on the 32-bit bus, and the lowest addressed byte is the most significant.
- R3: A read returns its data on `bus_rdata` one cycle after the request. In every other cycle `bus_rdata` is zero. A read has no side effect and may target record 0.
- R4: An access whose size is not 1, 2 or 4 changes no record. One cycle later it raises `bus_err` for one cycle, with `bus_rdata` zero.
- R5: Writes to record 0 change nothing and never release a core.
- R6: Writes to a record whose `core_present` bit is 0 change nothing and release nothing.
- R7: After every accepted write whose resulting jump address has bit 0 at 0, `rel_pulse[i]` is high for exactly the next cycle. Repeated such writes release the core again.
- R8: During a release pulse, the output buses carry values taken from the record as updated by that write:
  - `rel_start` is the jump address masked to its low 26 bits.
  - `rel_base` is the jump address with those 26 bits cleared.
  - `rel_arg` is the argument field.
  - `rel_win_size` is the constant 64 MiB.
- R9: A releasing write stores the core's hardware identifier from `core_hw_id[i*32 +: 32]` into the record's core-identifier field. This overrides any bytes that the same write put into that field.
- R10: At most one bit of `rel_pulse` is high in any cycle, and none without an accepted write in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address into the table |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Unsupported size flag, one cycle after the request |
| core_present | input | 32 | Per-core present mask |
| core_hw_id | input | 1024 | Per-core hardware identifier, 32 bits each |
| rel_pulse | output | 32 | One-hot release pulse |
| rel_start | output | 64 | Start offset inside the window |
| rel_base | output | 64 | Translation window base |
| rel_arg | output | 64 | Initial argument value |
| rel_win_size | output | 64 | Window size, constant 64 MiB |

## Verification
Every result of this block appears exactly one clock after the access that causes it. This holds for read data, the size error flag, the release pulse and the release buses. Record updates are visible to a read issued on the following access.

The bench drives each access just after a falling edge, lets one rising edge capture it, and compares all outputs at the next falling edge against a byte-array model. The model computes the expected record contents and release values. Writes that must be ignored are followed by a read-back of the same field.

// File: rtl/spin_pkg.sv
package spin_pkg;

  localparam int unsigned ENT_BYTES = 32;
  localparam int unsigned ENT_BITS  = ENT_BYTES * 8;
  localparam int unsigned OFF_W     = 5;

  typedef logic [ENT_BITS-1:0] entry_t;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [OFF_W-1:0] align_off(input logic [OFF_W-1:0] off,
                                                 input logic [2:0] sz);
    logic [OFF_W-1:0] m;
    m = {2'b00, sz} - 5'd1;
    return off & ~m;
  endfunction

  function automatic logic [7:0] get_byte(input entry_t e, input logic [OFF_W-1:0] b);
    entry_t t;
    t = e >> {~b, 3'b000};
    return t[7:0];
  endfunction

  function automatic logic [31:0] rd_pick(input entry_t e, input logic [OFF_W-1:0] off,
                                          input logic [2:0] sz);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(sz)) r = {r[23:0], get_byte(e, off + OFF_W'(k))};
    end
    return r;
  endfunction

  function automatic entry_t wr_merge(input entry_t e, input logic [OFF_W-1:0] off,
                                      input logic [2:0] sz, input logic [31:0] wd);
    entry_t r;
    r = e;
    for (int b = 0; b < int'(ENT_BYTES); b++) begin
      for (int k = 0; k < 4; k++) begin
        if ((k < int'(sz)) && (int'(off) + k == b))
          r[ENT_BITS-1-8*b -: 8] = 8'(wd >> (8 * (int'(sz) - 1 - k)));
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] win_low(input logic [63:0] a, input int unsigned wb);
    return a & ((64'd1 << wb) - 64'd1);
  endfunction

  function automatic logic [63:0] win_high(input logic [63:0] a, input int unsigned wb);
    return a & ~((64'd1 << wb) - 64'd1);
  endfunction

endpackage

// File: rtl/spin_entry.sv
module spin_entry
  import spin_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [2:0]       wr_size,
  input  logic [31:0]      wr_data,
  input  logic [31:0]      hw_id,
  output entry_t           ent_q,
  output logic             rel_hit,
  output logic [63:0]      nxt_addr,
  output logic [63:0]      nxt_arg
);

  entry_t merged;
  entry_t nxt;

  always_comb begin
    merged   = wr_merge(ent_q, wr_off, wr_size, wr_data);
    rel_hit  = wr_sel && !merged[ENT_BITS-64];
    nxt      = merged;
    if (rel_hit) nxt[95:64] = hw_id;
    nxt_addr = merged[ENT_BITS-1 -: 64];
    nxt_arg  = merged[ENT_BITS-65 -: 64];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ent_q <= {64'd1, 64'(IDX), 32'd0, 32'(IDX), 64'd0};
    else if (wr_sel) ent_q <= nxt;
  end

endmodule

// File: rtl/spin_read_port.sv
module spin_read_port
  import spin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_ok,
  input  logic             bad_size,
  input  entry_t           sel_ent,
  input  logic [OFF_W-1:0] rd_off,
  input  logic [2:0]       rd_size,
  output logic [31:0]      rdata,
  output logic             err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rd_ok ? rd_pick(sel_ent, rd_off, rd_size) : 32'd0;
      err   <= bad_size;
    end
  end

endmodule

// File: rtl/spin_release_out.sv
module spin_release_out
  import spin_pkg::*;
#(
  parameter int unsigned NUM_CORES = 32,
  parameter int unsigned WIN_BITS  = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] rel_hit,
  input  logic [63:0]          addr_in,
  input  logic [63:0]          arg_in,
  output logic [NUM_CORES-1:0] pulse,
  output logic [63:0]          start,
  output logic [63:0]          base,
  output logic [63:0]          arg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= '0;
      start <= '0;
      base  <= '0;
      arg   <= '0;
    end else begin
      pulse <= rel_hit;
      if (|rel_hit) begin
        start <= win_low(addr_in, WIN_BITS);
        base  <= win_high(addr_in, WIN_BITS);
        arg   <= arg_in;
      end
    end
  end

endmodule

// File: rtl/spin_release_bank.sv
module spin_release_bank
  import spin_pkg::*;
#(
  parameter  int unsigned NUM_CORES = 32,
  parameter  int unsigned WIN_BITS  = 26,
  localparam int unsigned IDX_W     = $clog2(NUM_CORES),
  localparam int unsigned ADDR_W    = IDX_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [2:0]              bus_size,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  input  logic [NUM_CORES-1:0]    core_present,
  input  logic [NUM_CORES*32-1:0] core_hw_id,
  output logic [NUM_CORES-1:0]    rel_pulse,
  output logic [63:0]             rel_start,
  output logic [63:0]             rel_base,
  output logic [63:0]             rel_arg,
  output logic [63:0]             rel_win_size
);

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] aoff;
  logic             sz_good;
  logic             idx_valid;
  logic             wr_ok;
  logic             rd_ok;
  logic             bad_size;

  entry_t                 ent_q   [NUM_CORES];
  logic [63:0]            nxt_addr[NUM_CORES];
  logic [63:0]            nxt_arg [NUM_CORES];
  logic [NUM_CORES-1:0]   rel_hit;
  logic [NUM_CORES-1:0]   wr_sel;

  assign idx     = bus_addr[ADDR_W-1:OFF_W];
  assign aoff    = align_off(bus_addr[OFF_W-1:0], bus_size);
  assign sz_good = size_ok(bus_size);

  generate
    if (NUM_CORES == (1 << IDX_W)) begin : g_full
      assign idx_valid = 1'b1;
    end else begin : g_part
      assign idx_valid = ({1'b0, idx} < (IDX_W+1)'(NUM_CORES));
    end
  endgenerate

  assign wr_ok    = bus_en && bus_we && sz_good && idx_valid && (idx != '0) && core_present[idx];
  assign rd_ok    = bus_en && !bus_we && sz_good && idx_valid;
  assign bad_size = bus_en && !sz_good;

  generate
    for (genvar i = 0; i < int'(NUM_CORES); i++) begin : g_ent
      assign wr_sel[i] = wr_ok && (idx == IDX_W'(i));
      spin_entry #(.IDX(i)) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel[i]),
        .wr_off   (aoff),
        .wr_size  (bus_size),
        .wr_data  (bus_wdata),
        .hw_id    (core_hw_id[i*32 +: 32]),
        .ent_q    (ent_q[i]),
        .rel_hit  (rel_hit[i]),
        .nxt_addr (nxt_addr[i]),
        .nxt_arg  (nxt_arg[i])
      );
    end
  endgenerate

  spin_read_port u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_ok    (rd_ok),
    .bad_size (bad_size),
    .sel_ent  (ent_q[idx]),
    .rd_off   (aoff),
    .rd_size  (bus_size),
    .rdata    (bus_rdata),
    .err      (bus_err)
  );

  spin_release_out #(.NUM_CORES(NUM_CORES), .WIN_BITS(WIN_BITS)) u_rel (
    .clk     (clk),
    .rst_n   (rst_n),
    .rel_hit (rel_hit),
    .addr_in (nxt_addr[idx]),
    .arg_in  (nxt_arg[idx]),
    .pulse   (rel_pulse),
    .start   (rel_start),
    .base    (rel_base),
    .arg     (rel_arg)
  );

  assign rel_win_size = 64'd1 << WIN_BITS;

endmodule

// File: rtl/spin_release_chk.sv
module spin_release_chk #(
  parameter int unsigned NUM_CORES = 32,
  parameter int unsigned WIN_BITS  = 26
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic                 wr_ok,
  input logic                 bad_size,
  input logic [31:0]          bus_rdata,
  input logic                 bus_err,
  input logic [NUM_CORES-1:0] rel_pulse,
  input logic [63:0]          rel_start,
  input logic [63:0]          rel_base
);

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_pulse)); // R10
  AST_NO_CORE0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_pulse[0]); // R5
  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> $past(wr_ok)); // R7
  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> ((rel_start >> WIN_BITS) == 64'd0)); // R8
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> ((rel_base & ((64'd1 << WIN_BITS) - 64'd1)) == 64'd0)); // R8
  AST_BAD_SIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad_size |=> (bus_err && (bus_rdata == 32'd0))); // R4
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bad_size)); // R4
  AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we) |=> (bus_rdata == 32'd0)); // R3

endmodule

bind spin_release_bank spin_release_chk #(.NUM_CORES(NUM_CORES), .WIN_BITS(WIN_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .wr_ok     (wr_ok),
  .bad_size  (bad_size),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .rel_pulse (rel_pulse),
  .rel_start (rel_start),
  .rel_base  (rel_base)
);

// File: tb/tb_spin_release_bank.sv
module tb_spin_release_bank;
  localparam int N  = 32;
  localparam int WB = 26;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]      bus_addr = '0;
  logic [2:0]      bus_size = 3'd4;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_err;
  logic [N-1:0]    core_present = '1;
  logic [N*32-1:0] core_hw_id;
  logic [N-1:0]    rel_pulse;
  logic [63:0]     rel_start, rel_base, rel_arg, rel_win_size;

  int checks = 0, fails = 0;
  logic [7:0] mdl [N][32];

  always #4 clk = ~clk;

  spin_release_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .core_present(core_present), .core_hw_id(core_hw_id), .rel_pulse(rel_pulse),
    .rel_start(rel_start), .rel_base(rel_base), .rel_arg(rel_arg), .rel_win_size(rel_win_size)
  );

  function automatic logic [31:0] hwid(int i);
    return 32'hA500_0000 + 32'(i * 17);
  endfunction

  function automatic logic [63:0] fld64(int e, int o);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) r = (r << 8) | 64'(mdl[e][o + k]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input int addr, input int sz, input logic [31:0] wd,
                        input string tag);
    int e, o, ao;
    bit good;
    logic [31:0] exp_rd;
    logic [N-1:0] exp_pulse;
    logic [63:0] a, exp_start, exp_base, exp_arg;
    e = addr / 32; o = addr % 32;
    good = (sz == 1) || (sz == 2) || (sz == 4);
    ao = good ? (o - (o % sz)) : o;
    exp_rd = '0; exp_pulse = '0; exp_start = '0; exp_base = '0; exp_arg = '0;
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = 10'(addr); bus_size = 3'(sz); bus_wdata = wd;
    if (good && !we)
      for (int k = 0; k < sz; k++) exp_rd = (exp_rd << 8) | 32'(mdl[e][ao + k]);
    if (good && we && e != 0 && core_present[e]) begin
      for (int k = 0; k < sz; k++) mdl[e][ao + k] = 8'(wd >> (8 * (sz - 1 - k)));
      a = fld64(e, 0);
      if (a % 2 == 0) begin
        exp_pulse[e] = 1'b1;
        exp_start = a % (64'd1 << WB);
        exp_base  = a - exp_start;
        exp_arg   = fld64(e, 8);
        for (int k = 0; k < 4; k++) mdl[e][20 + k] = 8'(hwid(e) >> (8 * (3 - k)));
      end
    end
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    chk(rel_pulse == exp_pulse, "R7 rel_pulse", 64'(rel_pulse), 64'(exp_pulse));
    chk(bus_err == !good, "R4 bus_err", 64'(bus_err), 64'(!good));
    chk(bus_rdata == exp_rd, tag, 64'(bus_rdata), 64'(exp_rd));
    if (|exp_pulse) begin
      chk(rel_start == exp_start, "R8 rel_start", rel_start, exp_start);
      chk(rel_base == exp_base, "R8 rel_base", rel_base, exp_base);
      chk(rel_arg == exp_arg, "R8 rel_arg", rel_arg, exp_arg);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      core_hw_id[i*32 +: 32] = hwid(i);
      for (int b = 0; b < 32; b++) mdl[i][b] = 8'h00;
      mdl[i][7] = 8'h01; mdl[i][15] = 8'(i); mdl[i][23] = 8'(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rel_pulse == '0, "R1 pulse after reset", 64'(rel_pulse), 64'd0);
    chk(bus_err == 1'b0 && bus_rdata == '0, "R1 bus idle after reset", 64'(bus_rdata), 64'd0);
    chk(rel_win_size == (64'd1 << WB), "R8 rel_win_size", rel_win_size, 64'd1 << WB);

    // R1: reset contents of every record
    for (int i = 0; i < N; i++) begin
      access(0, i*32 + 0,  4, 0, "R1 addr high");
      access(0, i*32 + 4,  4, 0, "R1 addr low");
      access(0, i*32 + 12, 4, 0, "R1 argument");
      access(0, i*32 + 20, 4, 0, "R1 core id");
      access(0, i*32 + 28, 4, 0, "R1 spare");
    end

    // R2: sizes, big-endian lanes, alignment
    access(1, 3*32 + 8,  1, 32'h0000_00AB, "R2 byte write");
    access(1, 3*32 + 11, 2, 32'h0000_1234, "R2 halfword write unaligned addr");
    access(1, 3*32 + 14, 4, 32'hDEAD_BEEF, "R2 word write unaligned addr");
    access(0, 3*32 + 8,  4, 0, "R2 word read");
    access(0, 3*32 + 15, 1, 0, "R2 byte read");
    access(0, 3*32 + 13, 2, 0, "R2 halfword read");

    // R7/R8/R9: release of core 3
    access(1, 3*32 + 0, 4, 32'h0000_0001, "R7 high half, still held");
    access(1, 3*32 + 4, 4, 32'h0512_3456, "R7 release write");
    access(0, 3*32 + 20, 4, 0, "R9 core id after release");
    access(1, 3*32 + 3, 1, 32'h0000_0002, "R7 second release");
    access(1, 3*32 + 20, 4, 32'h1111_2222, "R9 id write on released record");
    access(0, 3*32 + 20, 4, 0, "R9 id overridden");
    access(1, 3*32 + 7, 1, 32'h0000_0003, "R7 hold again");
    access(1, 3*32 + 22, 2, 32'h0000_7777, "R7 held write no pulse");
    access(0, 3*32 + 20, 4, 0, "R9 held id write kept");

    // R5: record 0
    access(1, 0*32 + 4, 4, 32'h0000_0000, "R5 write to record 0");
    access(0, 0*32 + 4, 4, 0, "R5 record 0 unchanged");

    // R6: absent core, then present
    core_present[5] = 1'b0;
    access(1, 5*32 + 4, 4, 32'h0000_0100, "R6 absent write");
    access(0, 5*32 + 4, 4, 0, "R6 absent record unchanged");
    core_present[5] = 1'b1;
    access(1, 5*32 + 6, 2, 32'h0000_0010, "R6 present release");

    // R4: unsupported sizes
    access(1, 7*32 + 4, 3, 32'h0000_0000, "R4 size 3 write rdata");
    access(0, 7*32 + 4, 4, 0, "R4 record unchanged");
    access(0, 7*32 + 4, 0, 0, "R4 size 0 read rdata");
    access(0, 7*32 + 4, 8, 0, "R4 size 8 read rdata");

    // R10 / boundary: last record, full address
    access(1, 31*32 + 0, 4, 32'hFFFF_FFFF, "R10 last record high");
    access(1, 31*32 + 8, 4, 32'h0BAD_F00D, "R10 last record argument");
    access(1, 31*32 + 4, 4, 32'hFFFF_FFFE, "R10 last record release");
    access(0, 31*32 + 20, 4, 0, "R9 last record id");
    access(1, 2*32 + 4, 4, 32'h0400_0000, "R10 zero start offset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule